// File: doc/BRIEF.md
# Timer Compare/Capture Channel Pair

This block serves two compare/capture channels that sit next to a free-running timer counter. Each channel owns one data register. In compare mode the register holds a threshold. The first cycle in which the counter equals that threshold produces a one-cycle match strobe, and the strobe drives a waveform state machine. In capture mode the register takes a snapshot of the counter whenever that channel's trigger is sampled high, and the channel's waveform pin stays low.

Five waveform behaviours are available: software level, set, toggle/reset, set/reset and toggle. The counter's direction selects the cycle-end clearing event, which is the MAX strobe for up or up/down counting and the ZERO strobe for down counting. A pairing flag ties the two channels together. The match of one channel then serves as the other channel's clearing event, or as a shared toggle or set source, so the two pins can run complementary sequences.

The counter, its prescaler and any interrupt logic live outside this block.

Top module: `ccp_pair`

## Requirements
- R1: Each data register is 0x0000 after reset, and both waveform pins are 0. Asserting wr_en[i] loads wr_data into register i at the next clock edge, and cc_dataI shows the register contents.
- R2: When cap_sel[i]=1 and cap_trig[i]=1, register i loads cnt_val at that clock edge. A capture takes priority over a write in the same cycle.
- R3: A channel in compare mode raises its match only in the first cycle in which cnt_val equals its register. Further cycles with equality held produce no new match.
- R4: Output mode code 0 (software) makes the internal state follow sw_lvl[i], one cycle later.
- R5: Output mode code 1 (set) makes the state go to 1 on a match and never return to 0 while the mode is unchanged.
- R6: Output mode code 4 (toggle) inverts the state on every match.
- R7: Output mode code 3 (set/reset), when unpaired, sets the state on a match. It clears the state on ev_max when cnt_dir is 0 (up) or 2 (up/down), and on ev_zero when cnt_dir is 1 (down).
- R8: Output mode code 2 (toggle/reset) inverts the state on a match and clears it on the same clearing event as R7.
- R9: With pair_en=1, each channel's clearing event in codes 2 and 3 is the other channel's match. In codes 1 and 4, a match of either channel sets or toggles both states.
- R10: When a clearing event and a set or toggle event fall in the same cycle, the state becomes 0.
- R11: wave_out[i] equals the state XOR pol_inv[i], registered, and updates at the same edge as the state. While cap_sel[i]=1, wave_out[i] is 0 whatever pol_inv[i] is.
- R12: A change of the output mode code clears the state at that edge. Codes 5 to 7 hold the state at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current timer counter value |
| ev_max | input | 1 | One-cycle strobe: counter at its top |
| ev_zero | input | 1 | One-cycle strobe: counter at zero |
| cnt_dir | input | 2 | Count direction: 0 up, 1 down, 2 up/down |
| cap_trig | input | 2 | Capture trigger per channel |
| wr_en | input | 2 | Register write enable per channel |
| wr_data | input | CNT_W | Register write data |
| mode_ch0 | input | 3 | Output mode code, channel 0 |
| mode_ch1 | input | 3 | Output mode code, channel 1 |
| pair_en | input | 1 | Pairs the two channels |
| pol_inv | input | 2 | Per-channel output inversion |
| sw_lvl | input | 2 | Per-channel software level |
| cap_sel | input | 2 | Per-channel capture (1) or compare (0) |
| wave_out | output | 2 | Registered waveform pins |
| cc_data0 | output | CNT_W | Channel 0 register contents |
| cc_data1 | output | CNT_W | Channel 1 register contents |

## Verification
A stale match-history bit shows up on the waveform pin in the cycle after the counter reaches the threshold: a held equality either produces a second toggle or suppresses the first one. A waveform state left wrong after a mode change or a simultaneous clear stays visible on wave_out until the next event. For that reason the reference model compares both pins and both registers on every clock, so a divergence is reported within one cycle of the edge that caused it. Paired runs use distinct thresholds, so a swapped cross-channel connection gives a different pin sequence.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [2:0] OM_SW     = 3'd0;
  localparam logic [2:0] OM_SET    = 3'd1;
  localparam logic [2:0] OM_TGRST  = 3'd2;
  localparam logic [2:0] OM_SETRST = 3'd3;
  localparam logic [2:0] OM_TOG    = 3'd4;
  localparam logic [1:0] DIR_DOWN  = 2'd1;
endpackage

// File: rtl/ccp_match.sv
module ccp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thr,
  output logic         hit
);
  logic eq, eq_q;

  assign eq  = cmp_en && (cnt == thr);
  assign hit = eq && !eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  // R3
  hit_single_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/ccp_reg.sv
module ccp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cap_en,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst)         data_o <= '0;
    else if (cap_en) data_o <= cnt;
    else if (wr_en)  data_o <= wr_data;
  end

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> data_o == $past(cnt));
  // R1
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cap_en) |=> data_o == $past(wr_data));
endmodule

// File: rtl/ccp_wave.sv
module ccp_wave
  import ccp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       pair,
  input  logic       cap,
  input  logic       sw_lvl,
  input  logic       pol,
  input  logic       own_hit,
  input  logic       oth_hit,
  input  logic       ev_max,
  input  logic       ev_zero,
  input  logic [1:0] dir,
  output logic       wave_o
);
  logic [2:0] mode_q;
  logic       st_q, st_nxt;
  logic       cyc_clr, set_ev, clr_ev, tog_ev;

  assign cyc_clr = (dir == DIR_DOWN) ? ev_zero : ev_max;

  always_comb begin
    if (pair) begin
      set_ev = (mode == OM_SET) ? (own_hit | oth_hit) : own_hit;
      clr_ev = oth_hit;
      tog_ev = own_hit | oth_hit;
    end else begin
      set_ev = own_hit;
      clr_ev = cyc_clr;
      tog_ev = own_hit;
    end
  end

  always_comb begin
    st_nxt = 1'b0;
    if (!cap && mode == mode_q) begin
      case (mode)
        OM_SW:     st_nxt = sw_lvl;
        OM_SET:    st_nxt = st_q | set_ev;
        OM_TGRST:  st_nxt = clr_ev ? 1'b0 : (set_ev ? !st_q : st_q);
        OM_SETRST: st_nxt = clr_ev ? 1'b0 : (set_ev ? 1'b1 : st_q);
        OM_TOG:    st_nxt = tog_ev ? !st_q : st_q;
        default:   st_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= 1'b0;
      mode_q <= OM_SW;
      wave_o <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      mode_q <= mode;
      wave_o <= cap ? 1'b0 : (st_nxt ^ pol);
    end
  end

  // R11
  cap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> !wave_o);
  // R12
  mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |=> !st_q);
  // R5
  set_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_SET && mode_q == OM_SET && !cap) |=> (st_q || !$past(st_q)));
  // R10
  clr_win_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == OM_TGRST || mode == OM_SETRST) && mode_q == mode && clr_ev) |=> !st_q);
  // R6
  tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_TOG && mode_q == OM_TOG && !cap && tog_ev) |=> st_q != $past(st_q));
endmodule

// File: rtl/ccp_pair.sv
module ccp_pair #(
  parameter int CNT_W = 16,
  localparam int NCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             ev_max,
  input  logic             ev_zero,
  input  logic [1:0]       cnt_dir,
  input  logic [1:0]       cap_trig,
  input  logic [1:0]       wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       mode_ch0,
  input  logic [2:0]       mode_ch1,
  input  logic             pair_en,
  input  logic [1:0]       pol_inv,
  input  logic [1:0]       sw_lvl,
  input  logic [1:0]       cap_sel,
  output logic [1:0]       wave_out,
  output logic [CNT_W-1:0] cc_data0,
  output logic [CNT_W-1:0] cc_data1
);
  logic [CNT_W-1:0] dat [NCH];
  logic [2:0]       md  [NCH];
  logic [NCH-1:0]   hit;

  assign md[0]    = mode_ch0;
  assign md[1]    = mode_ch1;
  assign cc_data0 = dat[0];
  assign cc_data1 = dat[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ccp_reg #(.W(CNT_W)) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en[i]), .wr_data(wr_data),
      .cap_en(cap_sel[i] & cap_trig[i]), .cnt(cnt_val), .data_o(dat[i])
    );
    ccp_match #(.W(CNT_W)) u_match (
      .clk(clk), .rst(rst), .cmp_en(!cap_sel[i]), .cnt(cnt_val),
      .thr(dat[i]), .hit(hit[i])
    );
    ccp_wave u_wave (
      .clk(clk), .rst(rst), .mode(md[i]), .pair(pair_en), .cap(cap_sel[i]),
      .sw_lvl(sw_lvl[i]), .pol(pol_inv[i]), .own_hit(hit[i]),
      .oth_hit(hit[NCH-1-i]), .ev_max(ev_max), .ev_zero(ev_zero),
      .dir(cnt_dir), .wave_o(wave_out[i])
    );
  end
endmodule

// File: tb/sim_ccp_pair.sv
module sim_ccp_pair;
  localparam int TOP = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt = '0;
  logic        evmx = 1'b0, evzr = 1'b0;
  logic [1:0]  dir = 2'd0;
  logic [1:0]  captrg = '0, wren = '0, pol = '0, sw = '0, capsel = '0;
  logic [15:0] wdat = '0;
  logic [2:0]  mode0 = '0, mode1 = '0;
  logic        pair = 1'b0;
  logic [1:0]  wave;
  logic [15:0] d0, d1;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit started = 0;

  always #4 clk = !clk;

  ccp_pair u0 (
    .clk(clk), .rst(rst), .cnt_val(cnt), .ev_max(evmx), .ev_zero(evzr),
    .cnt_dir(dir), .cap_trig(captrg), .wr_en(wren), .wr_data(wdat),
    .mode_ch0(mode0), .mode_ch1(mode1), .pair_en(pair), .pol_inv(pol),
    .sw_lvl(sw), .cap_sel(capsel), .wave_out(wave), .cc_data0(d0), .cc_data1(d1)
  );

  // behavioural reference
  logic [15:0] m_dat [2];
  logic [2:0]  m_mq [2];
  logic        m_st [2], m_eqp [2], m_wave [2];

  always @(posedge clk) begin
    logic h [2];
    logic eq [2];
    logic clr_u, ns;
    logic [2:0] md;
    started <= 1;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_dat[i] = '0; m_mq[i] = '0; m_st[i] = 0; m_eqp[i] = 0; m_wave[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        eq[i] = !capsel[i] && (cnt == m_dat[i]);
        h[i] = eq[i] && !m_eqp[i];
        m_eqp[i] = eq[i];
        if (capsel[i] && captrg[i]) m_dat[i] = cnt;
        else if (wren[i]) m_dat[i] = wdat;
      end
      clr_u = (dir == 2'd1) ? evzr : evmx;
      for (int i = 0; i < 2; i++) begin
        md = (i == 0) ? mode0 : mode1;
        ns = 0;
        if (!capsel[i] && md == m_mq[i]) begin
          case (md)
            3'd0: ns = sw[i];
            3'd1: ns = m_st[i] | h[i] | (pair & h[1-i]);
            3'd2: ns = (pair ? h[1-i] : clr_u) ? 1'b0 : (h[i] ? !m_st[i] : m_st[i]);
            3'd3: ns = (pair ? h[1-i] : clr_u) ? 1'b0 : (h[i] ? 1'b1 : m_st[i]);
            3'd4: ns = (h[i] | (pair & h[1-i])) ? !m_st[i] : m_st[i];
            default: ns = 0;
          endcase
        end
        m_mq[i] = md;
        m_st[i] = ns;
        m_wave[i] = capsel[i] ? 1'b0 : (ns ^ pol[i]);
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < 2; i++) begin
        checks++;
        if (wave[i] !== m_wave[i]) begin
          failures++;
          $display("FAIL %s wave_out[%0d] actual=%b expected=%b t=%0t", phase, i, wave[i], m_wave[i], $time);
        end
      end
      checks++;
      if (d0 !== m_dat[0]) begin
        failures++;
        $display("FAIL %s cc_data0 actual=%h expected=%h t=%0t", phase, d0, m_dat[0], $time);
      end
      checks++;
      if (d1 !== m_dat[1]) begin
        failures++;
        $display("FAIL %s cc_data1 actual=%h expected=%h t=%0t", phase, d1, m_dat[1], $time);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(input int from, input int to, input logic [1:0] d);
    int step = (to >= from) ? 1 : -1;
    dir = d;
    for (int v = from; v != to + step; v += step) begin
      cnt  = 16'(v);
      evmx = (v == TOP);
      evzr = (v == 0);
      tick();
    end
    evmx = 0; evzr = 0;
  endtask

  task automatic wr(input int ch, input int val);
    wdat = 16'(val); wren = (ch == 0) ? 2'b01 : 2'b10;
    tick();
    wren = '0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    phase = "R1"; tick(2);
    wr(0, 5); wr(1, 9); cnt = 16'd100; tick(2);
    phase = "R4"; mode0 = 3'd0; mode1 = 3'd0;
    sw = 2'b01; tick(2); sw = 2'b10; tick(2); sw = 2'b00; tick(2);
    phase = "R5"; mode0 = 3'd1; mode1 = 3'd1; tick();
    sweep(0, TOP, 2'd0); sweep(0, TOP, 2'd0);
    phase = "R3"; mode0 = 3'd4; mode1 = 3'd4; tick();
    cnt = 16'd5; tick(4); cnt = 16'd6; tick(); cnt = 16'd5; tick(3); cnt = 16'd9; tick(3);
    phase = "R6"; sweep(0, TOP, 2'd0); sweep(0, TOP, 2'd0);
    phase = "R7"; mode0 = 3'd3; mode1 = 3'd3; tick();
    sweep(0, TOP, 2'd0); sweep(TOP, 0, 2'd1); sweep(0, TOP, 2'd2); sweep(TOP, 0, 2'd2);
    phase = "R8"; mode0 = 3'd2; mode1 = 3'd2; tick();
    sweep(0, TOP, 2'd0); sweep(TOP, 0, 2'd1);
    phase = "R10"; wr(0, TOP); wr(1, 0); mode0 = 3'd3; mode1 = 3'd3; tick();
    sweep(0, TOP, 2'd0); sweep(TOP, 0, 2'd1);
    mode0 = 3'd2; mode1 = 3'd2; tick();
    sweep(0, TOP, 2'd0); sweep(TOP, 0, 2'd1);
    phase = "R9"; wr(0, 5); wr(1, 9); pair = 1;
    mode0 = 3'd3; mode1 = 3'd3; tick(); sweep(0, TOP, 2'd0); sweep(0, TOP, 2'd0);
    mode0 = 3'd4; mode1 = 3'd4; tick(); sweep(0, TOP, 2'd0);
    mode0 = 3'd1; mode1 = 3'd1; tick(); sweep(0, TOP, 2'd0);
    mode0 = 3'd2; mode1 = 3'd2; tick(); sweep(0, TOP, 2'd0); sweep(0, TOP, 2'd0);
    wr(1, 5); mode0 = 3'd3; mode1 = 3'd3; tick(); sweep(0, TOP, 2'd0);
    pair = 0; wr(1, 9);
    phase = "R11"; mode0 = 3'd4; mode1 = 3'd4; pol = 2'b11; tick();
    sweep(0, TOP, 2'd0); pol = 2'b01; sweep(0, TOP, 2'd0);
    capsel = 2'b11; pol = 2'b11; tick(3); sweep(0, TOP, 2'd0); capsel = 2'b00; tick(2); pol = 2'b00;
    phase = "R2"; capsel = 2'b01; cnt = 16'd33; captrg = 2'b01; tick(); captrg = 2'b00;
    cnt = 16'd44; tick(2);
    cnt = 16'd77; captrg = 2'b11; wdat = 16'h1234; wren = 2'b11; tick();
    captrg = 2'b00; wren = 2'b00; tick(2);
    capsel = 2'b10; cnt = 16'd8; captrg = 2'b10; tick(); captrg = 2'b00; capsel = 2'b00; tick(2);
    phase = "R12"; wr(0, 5); wr(1, 9); mode0 = 3'd1; mode1 = 3'd1; tick();
    sweep(0, 10, 2'd0); mode0 = 3'd4; mode1 = 3'd3; tick(3);
    mode0 = 3'd6; mode1 = 3'd5; sweep(0, TOP, 2'd0); mode0 = 3'd7; pol = 2'b11; tick(3);
    pol = 2'b00; mode0 = 3'd0; sw = 2'b11; tick(2); mode0 = 3'd1; tick(2);
    phase = "R1"; rst = 1; tick(2); rst = 0; tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule